// File: doc/BRIEF.md
# Real-Time Clock Alarm Compare and Interrupt Flag Unit

This unit sits beside the timekeeping counters of a real-time clock. On each update-ended tick it checks the current seconds, minutes and hours against three alarm bytes. It gathers three kinds of events into one host-visible flag byte: alarm match, periodic tick and update completion. From that byte it drives a single active-high interrupt request.

The time fields are compared as raw bytes. The same logic therefore serves BCD and binary encodings, and it also serves hour values that carry an AM/PM marker bit. An alarm byte whose two upper bits are both one acts as a wildcard for its field. The host reads the flag byte with a one-cycle read strobe. The value seen during the strobe cycle is the value before the clear, and every flag is cleared at the end of that cycle. An event that arrives in the same cycle as the strobe is kept.

Top module: `rtc_irq_flags`

## Requirements
- R1: On a cycle with `upd_tick_i` high, flag bit 5 (alarm) becomes 1 after that clock edge only if each of seconds, minutes and hours equals its alarm byte bit for bit, or is wildcarded.
- R2: An alarm byte with bits 7 and 6 both 1 (0xC0 to 0xFF) matches any value of its field. A byte with only one of those bits set (for example 0x80 or 0xBF) is compared normally.
- R3: The flag byte layout is: bit 7 is the summary bit, bit 6 is periodic, bit 5 is alarm and bit 4 is update-ended. Bits 3 to 0 always read 0.
- R4: A `per_tick_i` pulse sets bit 6 and an `upd_tick_i` pulse sets bit 4 after the clock edge, whatever the enables are. A set flag stays set until it is read or reset.
- R5: Bit 7 is 1 exactly when some flag among bits 6, 5 and 4 is 1 while its enable (`per_ie_i`, `alm_ie_i`, `upd_ie_i` respectively) is 1. It follows enable changes in the same cycle. `irq_o` always equals bit 7.
- R6: In a cycle with `rd_flags_i` high, `flags_o` shows the current flags. After that clock edge, every flag with no new event in that cycle reads 0.
- R7: An event in the same cycle as `rd_flags_i` leaves its flag set after the edge, so the event is seen by the next read.
- R8: A synchronous reset (`rst_n` low at a clock edge) clears all flags, so `flags_o` is 0x00 and `irq_o` is 0.
- R9: When `upd_tick_i` is low, the alarm flag is not set, even when all three fields match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_now_i | input | 8 | Current seconds byte |
| min_now_i | input | 8 | Current minutes byte |
| hr_now_i | input | 8 | Current hours byte |
| sec_alarm_i | input | 8 | Seconds alarm byte |
| min_alarm_i | input | 8 | Minutes alarm byte |
| hr_alarm_i | input | 8 | Hours alarm byte |
| per_ie_i | input | 1 | Periodic interrupt enable |
| alm_ie_i | input | 1 | Alarm interrupt enable |
| upd_ie_i | input | 1 | Update-ended interrupt enable |
| per_tick_i | input | 1 | Single-cycle periodic event pulse |
| upd_tick_i | input | 1 | Single-cycle update-ended pulse, once per second |
| rd_flags_i | input | 1 | Flag read strobe; clears flags at the clock edge |
| irq_o | output | 1 | Active-high interrupt request |
| flags_o | output | 8 | Flag byte |

## Verification
The assertions take three things for granted about the inputs:
- The time fields and alarm bytes are stable in any cycle where `upd_tick_i` is high.
- The event inputs are clean, known levels after reset.
- The read strobe is a plain level that lasts the cycle in which the host samples `flags_o`.

The bench drives every input on the falling clock edge and holds it for a full cycle. It raises each tick for one cycle only, and it changes time and alarm values only while no tick is active. This keeps every sampled comparison well defined.

// File: rtl/rtc_irq_pkg.sv
// Shared constants for the alarm compare and interrupt flag unit.
// Assumes the flag bits occupy a contiguous run directly below the
// summary bit, ordered update-ended, alarm, periodic from LSB upward.
package rtc_irq_pkg;
    localparam int FIELD_W    = 8;   // width of one time or alarm byte
    localparam int NUM_FIELDS = 3;   // seconds, minutes, hours
    localparam int WILD_BITS  = 2;   // upper bits that mark a wildcard
    localparam int NUM_FLAGS  = 3;   // update-ended, alarm, periodic
    localparam int FLAG_LSB   = 4;   // byte position of the lowest flag
    localparam int SUM_BIT    = FLAG_LSB + NUM_FLAGS; // summary bit
    localparam int IDX_UPD    = 0;
    localparam int IDX_ALM    = 1;
    localparam int IDX_PER    = 2;
endpackage

// File: rtl/rtc_alarm_match.sv
// Compares each current time field with its alarm byte.
// A field hits when the bytes are equal or when the alarm byte has all
// WILD_BITS upper bits set. The compare is purely combinational and
// works on raw bytes, so it does not depend on the number encoding.
// Assumes the fields are packed LSB-first: seconds, minutes, hours.
module rtc_alarm_match #(
    parameter int FIELD_W    = 8,
    parameter int NUM_FIELDS = 3,
    parameter int WILD_BITS  = 2
) (
    input  logic [NUM_FIELDS*FIELD_W-1:0] now_vals,
    input  logic [NUM_FIELDS*FIELD_W-1:0] alarm_vals,
    output logic [NUM_FIELDS-1:0]         field_hit,
    output logic                          all_hit
);
    localparam int WILD_LO = FIELD_W - WILD_BITS;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        logic [FIELD_W-1:0] now_b;
        logic [FIELD_W-1:0] alm_b;
        logic               wild;
        // Slice one field and decide whether it matches.
        always_comb begin
            now_b        = now_vals[g*FIELD_W +: FIELD_W];
            alm_b        = alarm_vals[g*FIELD_W +: FIELD_W];
            wild         = &alm_b[FIELD_W-1:WILD_LO];
            field_hit[g] = wild || (now_b == alm_b);
        end
    end

    // All fields must hit for an alarm.
    always_comb all_hit = &field_hit;
endmodule

// File: rtl/rtc_flag_reg.sv
// Sticky event flags with a clear-on-read strobe.
// Each bit is set by its event pulse and holds until a read strobe.
// A set in the same cycle as a clear wins, so no event is lost.
// Assumes a synchronous active-low reset.
module rtc_flag_reg #(
    parameter int NUM_FLAGS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] set_ev,
    input  logic                 clr_rd,
    output logic [NUM_FLAGS-1:0] q
);
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_bit
        // Hold, clear on read, or set on event (set has priority).
        always_ff @(posedge clk) begin
            if (!rst_n)         q[i] <= 1'b0;
            else if (set_ev[i]) q[i] <= 1'b1;
            else if (clr_rd)    q[i] <= 1'b0;
        end

        // R7
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_ev[i] |=> q[i]);

        // R4
        sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_ev[i] && !clr_rd) |=> (q[i] == $past(q[i])));
    end

    // R6
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rd && (set_ev == '0)) |=> (q == '0));
endmodule

// File: rtl/rtc_irq_combine.sv
// Builds the host-visible flag byte from the sticky flags and enables.
// The summary bit is set when any flag is set together with its enable.
// Bits below FLAG_LSB are tied to zero. Purely combinational.
module rtc_irq_combine #(
    parameter int NUM_FLAGS = 3,
    parameter int FLAG_LSB  = 4,
    parameter int BYTE_W    = 8
) (
    input  logic [NUM_FLAGS-1:0] flags,
    input  logic [NUM_FLAGS-1:0] enables,
    output logic                 summary,
    output logic [BYTE_W-1:0]    flag_byte
);
    localparam int SUM_POS = FLAG_LSB + NUM_FLAGS;

    logic [NUM_FLAGS-1:0] gated;

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_gate
        // Mask one flag by its enable.
        always_comb gated[i] = flags[i] && enables[i];
    end

    // Assemble the byte: summary on top, flags below it, zeros low.
    always_comb begin
        summary                              = |gated;
        flag_byte                            = '0;
        flag_byte[FLAG_LSB +: NUM_FLAGS]     = flags;
        flag_byte[SUM_POS]                   = summary;
    end
endmodule

// File: rtl/rtc_irq_flags.sv
// Top of the alarm compare and interrupt flag unit.
// Checks the time against the alarm bytes on each update-ended tick,
// keeps sticky periodic/alarm/update flags, clears them on a host read
// and raises irq_o when an enabled flag is pending.
// Assumes time and alarm bytes are stable while upd_tick_i is high.
module rtc_irq_flags
    import rtc_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] sec_now_i,
    input  logic [7:0] min_now_i,
    input  logic [7:0] hr_now_i,
    input  logic [7:0] sec_alarm_i,
    input  logic [7:0] min_alarm_i,
    input  logic [7:0] hr_alarm_i,
    input  logic       per_ie_i,
    input  logic       alm_ie_i,
    input  logic       upd_ie_i,
    input  logic       per_tick_i,
    input  logic       upd_tick_i,
    input  logic       rd_flags_i,
    output logic       irq_o,
    output logic [7:0] flags_o
);
    localparam int VEC_W = NUM_FIELDS * FIELD_W;

    logic [VEC_W-1:0]      now_vec;
    logic [VEC_W-1:0]      alm_vec;
    logic [NUM_FIELDS-1:0] field_hit;
    logic                  all_hit;
    logic [NUM_FLAGS-1:0]  set_ev;
    logic [NUM_FLAGS-1:0]  flag_q;
    logic [NUM_FLAGS-1:0]  ie_vec;
    logic                  summary;

    // Pack time and alarm fields, seconds in the low byte.
    always_comb begin
        now_vec = {hr_now_i, min_now_i, sec_now_i};
        alm_vec = {hr_alarm_i, min_alarm_i, sec_alarm_i};
    end

    rtc_alarm_match #(
        .FIELD_W   (FIELD_W),
        .NUM_FIELDS(NUM_FIELDS),
        .WILD_BITS (WILD_BITS)
    ) u_match (
        .now_vals  (now_vec),
        .alarm_vals(alm_vec),
        .field_hit (field_hit),
        .all_hit   (all_hit)
    );

    // Route events and enables into flag index order.
    always_comb begin
        set_ev          = '0;
        set_ev[IDX_UPD] = upd_tick_i;
        set_ev[IDX_ALM] = upd_tick_i && all_hit;
        set_ev[IDX_PER] = per_tick_i;
        ie_vec          = '0;
        ie_vec[IDX_UPD] = upd_ie_i;
        ie_vec[IDX_ALM] = alm_ie_i;
        ie_vec[IDX_PER] = per_ie_i;
    end

    rtc_flag_reg #(
        .NUM_FLAGS(NUM_FLAGS)
    ) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_ev(set_ev),
        .clr_rd(rd_flags_i),
        .q     (flag_q)
    );

    rtc_irq_combine #(
        .NUM_FLAGS(NUM_FLAGS),
        .FLAG_LSB (FLAG_LSB),
        .BYTE_W   (FIELD_W)
    ) u_comb (
        .flags    (flag_q),
        .enables  (ie_vec),
        .summary  (summary),
        .flag_byte(flags_o)
    );

    // Interrupt request follows the summary bit.
    always_comb irq_o = summary;

    // R9
    alarm_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_o[FLAG_LSB + IDX_ALM]) |-> $past(upd_tick_i));

    // R2
    wildcard_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_tick_i && (&sec_alarm_i[7:6]) && (&min_alarm_i[7:6]) &&
         (&hr_alarm_i[7:6])) |=> flags_o[FLAG_LSB + IDX_ALM]);

    // R5
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!per_ie_i && !alm_ie_i && !upd_ie_i) |-> !irq_o);

    // R3
    low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[FLAG_LSB-1:0] == '0);

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (flags_o == 8'h00 && !irq_o));
endmodule

// File: tb/rtc_irq_flags_bench.sv
module rtc_irq_flags_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] sec_now, min_now, hr_now, sec_alm, min_alm, hr_alm;
    logic       per_ie, alm_ie, upd_ie, per_tick, upd_tick, rd;
    logic       irq;
    logic [7:0] flags;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;   // 250 MHz

    rtc_irq_flags u_rtc_irq_flags (
        .clk(clk), .rst_n(rst_n),
        .sec_now_i(sec_now), .min_now_i(min_now), .hr_now_i(hr_now),
        .sec_alarm_i(sec_alm), .min_alarm_i(min_alm), .hr_alarm_i(hr_alm),
        .per_ie_i(per_ie), .alm_ie_i(alm_ie), .upd_ie_i(upd_ie),
        .per_tick_i(per_tick), .upd_tick_i(upd_tick), .rd_flags_i(rd),
        .irq_o(irq), .flags_o(flags)
    );

    typedef struct packed {
        logic [7:0] s, m, h, as, am, ah;
        logic [2:0] en;   // {per, alm, upd}
        logic       per, upd;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{8'h56,8'h34,8'h12, 8'h56,8'h34,8'h12, 3'b000, 1'b0,1'b1, 8'h30}, // R1 R4
        '{8'h56,8'h34,8'h12, 8'h56,8'h34,8'h12, 3'b010, 1'b0,1'b1, 8'hB0}, // R5
        '{8'h56,8'h34,8'h12, 8'h57,8'h34,8'h12, 3'b111, 1'b0,1'b1, 8'h90}, // R1
        '{8'h56,8'h34,8'h12, 8'hC0,8'hC0,8'hC0, 3'b000, 1'b0,1'b1, 8'h30}, // R2
        '{8'h56,8'h34,8'h12, 8'hFF,8'hD5,8'h12, 3'b100, 1'b0,1'b1, 8'h30}, // R2 R5
        '{8'h56,8'h34,8'h12, 8'h00,8'h00,8'h00, 3'b100, 1'b1,1'b0, 8'hC0}, // R4
        '{8'h56,8'h34,8'h12, 8'h00,8'h00,8'h00, 3'b000, 1'b1,1'b0, 8'h40}, // R4
        '{8'h56,8'h34,8'h12, 8'h56,8'h34,8'h12, 3'b111, 1'b0,1'b0, 8'h00}, // R9
        '{8'h56,8'h34,8'h12, 8'hBF,8'h34,8'h12, 3'b001, 1'b0,1'b1, 8'h90}, // R2
        '{8'h56,8'h34,8'h12, 8'h56,8'hC3,8'h12, 3'b111, 1'b1,1'b1, 8'hF0}, // R5
        '{8'h3B,8'h3B,8'h17, 8'h3B,8'h3B,8'h17, 3'b000, 1'b0,1'b1, 8'h30}, // R1
        '{8'h12,8'h00,8'h92, 8'h12,8'h00,8'h80, 3'b000, 1'b0,1'b1, 8'h10}  // R2
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        per_tick = 1'b0; upd_tick = 1'b0; rd = 1'b0;
    endtask

    // Clear via a read cycle with no events (we sit on a falling edge).
    task automatic clear_read();
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        sec_now = 8'h00; min_now = 8'h00; hr_now = 8'h00;
        sec_alm = 8'h01; min_alm = 8'h01; hr_alm = 8'h01;
        per_ie = 1'b0; alm_ie = 1'b0; upd_ie = 1'b0;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: state after reset
        chk("R8 reset flags", flags, 8'h00);
        chk("R8 reset irq", {7'd0, irq}, 8'h00);

        for (int k = 0; k < NV; k++) begin
            sec_now = TBL[k].s;  min_now = TBL[k].m;  hr_now = TBL[k].h;
            sec_alm = TBL[k].as; min_alm = TBL[k].am; hr_alm = TBL[k].ah;
            {per_ie, alm_ie, upd_ie} = TBL[k].en;
            per_tick = TBL[k].per; upd_tick = TBL[k].upd;
            @(negedge clk);
            idle_inputs();
            chk($sformatf("R1/R3 vector %0d flags", k), flags, TBL[k].exp);
            chk($sformatf("R5 vector %0d irq", k), {7'd0, irq}, {7'd0, TBL[k].exp[7]});
            clear_read();
        end

        // R4: flags stay set over idle cycles
        per_ie = 1'b0; alm_ie = 1'b0; upd_ie = 1'b0;
        per_tick = 1'b1;
        @(negedge clk);
        idle_inputs();
        repeat (4) @(negedge clk);
        chk("R4 sticky", flags, 8'h40);
        // R5: enable raised later raises irq in the same cycle
        per_ie = 1'b1;
        #1;
        chk("R5 enable late", flags, 8'hC0);
        chk("R5 irq late", {7'd0, irq}, 8'h01);
        @(negedge clk);
        // R6: read cycle shows old value, cleared after edge
        rd = 1'b1;
        #1;
        chk("R6 read value", flags, 8'hC0);
        @(negedge clk);
        rd = 1'b0;
        chk("R6 cleared", flags, 8'h00);
        chk("R6 irq cleared", {7'd0, irq}, 8'h00);

        // R7: event coinciding with read is kept, others cleared
        sec_now = 8'h10; sec_alm = 8'h10; min_now = 8'h20; min_alm = 8'h20;
        hr_now = 8'h05; hr_alm = 8'h05;
        upd_tick = 1'b1;
        @(negedge clk);
        idle_inputs();
        chk("R7 setup", flags, 8'h30);
        rd = 1'b1; per_tick = 1'b1;
        @(negedge clk);
        idle_inputs();
        chk("R7 set wins over read", flags, 8'hC0);
        clear_read();
        chk("R7 seen then cleared", flags, 8'h00);

        // R8: reset mid-run clears pending flags
        upd_ie = 1'b1; upd_tick = 1'b1;
        @(negedge clk);
        idle_inputs();
        chk("R8 pre-reset", flags, 8'hB0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R8 mid-run reset", flags, 8'h00);
        chk("R8 mid-run irq", {7'd0, irq}, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule